// File: doc/BRIEF.md
# Register-Mapped Reconfiguration Port Bridge

This block gives a host processor a small window of 32-bit registers that lets it run one transaction at a time on a dynamic reconfiguration port. The port has a one-cycle enable strobe, a write-enable, an address, write data, returned read data and a ready handshake from the component behind it. The first four words form a read-only header: a type code, a version code, a pointer to the next block in a chain of register blocks, and an info word that identifies what sits behind the port. The header lets discovery software walk the chain.

The host loads the address register and, for a write, the write-data register. It then writes the control word. Bit 0 of the control word launches the transaction and bit 1 selects a write. The host polls the control word until the enable and busy flags drop, then collects the result from the read-data register. A timeout frees the block if the component never answers.

Top module: `recfg_port_regs`

## Requirements
- R1: The header words are read-only. Word 0x00 reads 0x0000C150, word 0x04 reads 0x00000100, word 0x08 reads parameter NEXT_PTR and word 0x0C reads parameter INFO_WORD. Host writes to these words change nothing.
- R2: After a synchronous active-low reset, the control, address, write-data and read-data words read zero, port_en and port_we are low, and host_rdata is zero.
- R3: A read strobe at byte offset A in cycle c makes host_rdata show the word at A from the following cycle on, and host_rdata holds until the next read strobe. Word 0x14 returns the low PA_W bits of the last value written there, zero-extended. Word 0x18 returns the low PD_W bits, zero-extended. Offsets at or above 0x20 read zero.
- R4: port_addr always equals the address register.
- R5: port_wdata always equals the write-data register.
- R6: A control write with bit 0 set is accepted while the block is idle. It makes port_en high for exactly the one cycle after the write, and port_we equals bit 1 of the written value during that cycle. port_we is low whenever port_en is low. Every accepted control write stores its bit 1, and the control word returns that bit as bit 1.
- R7: From the cycle after a launch, control bits 0 (enable) and 8 (busy) read 1. They read 0 once port_rdy has been seen high while busy, including in the port_en cycle itself.
- R8: On a read transaction, port_rdata is captured into word 0x1C in the cycle that port_rdy is seen. A write transaction leaves word 0x1C unchanged.
- R9: Control writes made while busy are ignored. They produce no port_en pulse and do not change the stored write bit.
- R10: If port_rdy is not seen within TIMEOUT cycles of the launch, busy and enable clear and word 0x1C is unchanged.
- R11: port_rdy while idle has no effect: control and word 0x1C are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | HOST_AW | Byte offset of the register access |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 32 | Write data from host |
| host_rdata | output | 32 | Registered read data to host |
| port_en | output | 1 | One-cycle transaction strobe |
| port_we | output | 1 | Write select, valid with port_en |
| port_addr | output | PA_W | Transaction address |
| port_wdata | output | PD_W | Transaction write data |
| port_rdata | input | PD_W | Data returned by the component |
| port_rdy | input | 1 | Transaction completion from the component |

## Verification
The bench drives read transactions that complete a few cycles after the strobe and read transactions that complete inside the strobe cycle itself. These two cases separate correct capture timing from capture that happens one cycle late. It also drives write transactions, whose returned data must not reach the read-data word, and a relaunch attempted while busy, which exposes any missing busy guard. Transactions that never receive ready and a ready pulse sent while idle show whether the timeout and the idle filtering work. Header writes and an oversized address value show the read-only words and the width masking.

// File: rtl/recfg_pkg.sv
// Package: register offsets, header constants and control bit positions
// shared by the reconfiguration port bridge.
// Assumes 32-bit word-aligned host accesses inside a 32-byte window.
package recfg_pkg;
    localparam logic [2:0] W_TYPE  = 3'd0;
    localparam logic [2:0] W_VER   = 3'd1;
    localparam logic [2:0] W_NEXT  = 3'd2;
    localparam logic [2:0] W_INFO  = 3'd3;
    localparam logic [2:0] W_CTRL  = 3'd4;
    localparam logic [2:0] W_ADDR  = 3'd5;
    localparam logic [2:0] W_WDAT  = 3'd6;
    localparam logic [2:0] W_RDAT  = 3'd7;

    localparam logic [31:0] HDR_TYPE = 32'h0000_C150;
    localparam logic [31:0] HDR_VER  = 32'h0000_0100;

    localparam int CB_EN   = 0;
    localparam int CB_WR   = 1;
    localparam int CB_BUSY = 8;
endpackage

// File: rtl/recfg_timeout.sv
// Module: watchdog for one outstanding port transaction.
// Counts cycles while busy without ready; raises expire in the last allowed
// cycle. Assumes TIMEOUT >= 2.
module recfg_timeout #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic busy,
    input  logic rdy,
    output logic expire
);
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Expire fires on the last busy cycle that is still allowed.
    assign expire = busy && (cnt_q == LAST);

    // Count busy cycles; restart on each launch and while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || arm || !busy) begin
            cnt_q <= '0;
        end else if (!rdy && !expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: after expiry the engine must drop busy.
    a_r10_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !arm) |=> !busy);
endmodule

// File: rtl/recfg_xact_engine.sv
// Module: launches one port transaction and tracks it until ready or timeout.
// Assumes start is only offered while not busy (guarded by the register file).
module recfg_xact_engine #(
    parameter int PD_W    = 16,
    parameter int TIMEOUT = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_accept,
    input  logic            start,
    input  logic            wbit,
    input  logic            port_rdy,
    input  logic [PD_W-1:0] port_rdata,
    output logic            port_en,
    output logic            port_we,
    output logic            busy,
    output logic            we_bit,
    output logic            cap_en,
    output logic [PD_W-1:0] cap_data
);
    logic expire;

    recfg_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (start),
        .busy   (busy),
        .rdy    (port_rdy),
        .expire (expire)
    );

    // Read data is taken only when a read transaction completes.
    assign cap_en   = busy && port_rdy && !we_bit;
    assign cap_data = port_rdata;

    // Strobe the port for one cycle on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en <= 1'b0;
            port_we <= 1'b0;
        end else begin
            port_en <= start;
            port_we <= start && wbit;
        end
    end

    // Keep the write bit of the last accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n)           we_bit <= 1'b0;
        else if (ctrl_accept) we_bit <= wbit;
    end

    // Busy from launch until ready or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                             busy <= 1'b0;
        else if (start)                         busy <= 1'b1;
        else if (busy && (port_rdy || expire))  busy <= 1'b0;
    end

    // R6: the enable strobe lasts one cycle.
    a_r6_en_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> !port_en);
    // R6: write select only accompanies the strobe.
    a_r6_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |-> port_en);
    // R7: a strobe always belongs to a tracked transaction.
    a_r7_en_busy: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> busy);
    // R9: no launch is offered while a transaction is outstanding.
    a_r9_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/recfg_reg_file.sv
// Module: host register decode, storage and registered readback.
// Assumes word-aligned offsets; low two address bits are ignored.
module recfg_reg_file
    import recfg_pkg::*;
#(
    parameter int          HOST_AW   = 8,
    parameter int          PA_W      = 10,
    parameter int          PD_W      = 16,
    parameter logic [31:0] NEXT_PTR  = 32'h0,
    parameter logic [31:0] INFO_WORD = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               busy,
    input  logic               we_bit,
    input  logic               cap_en,
    input  logic [PD_W-1:0]    cap_data,
    output logic               ctrl_accept,
    output logic               start,
    output logic               wbit,
    output logic [PA_W-1:0]    addr_q,
    output logic [PD_W-1:0]    wdat_q
);
    logic            in_win;
    logic [2:0]      widx;
    logic [PD_W-1:0] rdat_q;
    logic [31:0]     rd_mux;

    // Word select within the 32-byte window.
    assign in_win = (host_addr >> 5) == '0;
    assign widx   = host_addr[4:2];

    // Control writes count only while idle.
    assign ctrl_accept = host_wr && in_win && (widx == W_CTRL) && !busy;
    assign start       = ctrl_accept && host_wdata[CB_EN];
    assign wbit        = host_wdata[CB_WR];

    // Store the transaction address.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    addr_q <= '0;
        else if (host_wr && in_win && widx == W_ADDR)  addr_q <= host_wdata[PA_W-1:0];
    end

    // Store the transaction write data.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    wdat_q <= '0;
        else if (host_wr && in_win && widx == W_WDAT)  wdat_q <= host_wdata[PD_W-1:0];
    end

    // Capture returned data at the end of a read transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdat_q <= '0;
        else if (cap_en) rdat_q <= cap_data;
    end

    // Select the addressed word.
    always_comb begin
        rd_mux = '0;
        if (in_win) begin
            unique case (widx)
                W_TYPE: rd_mux = HDR_TYPE;
                W_VER:  rd_mux = HDR_VER;
                W_NEXT: rd_mux = NEXT_PTR;
                W_INFO: rd_mux = INFO_WORD;
                W_CTRL: begin
                    rd_mux[CB_EN]   = busy;
                    rd_mux[CB_WR]   = we_bit;
                    rd_mux[CB_BUSY] = busy;
                end
                W_ADDR: rd_mux = 32'(addr_q);
                W_WDAT: rd_mux = 32'(wdat_q);
                W_RDAT: rd_mux = 32'(rdat_q);
                default: rd_mux = '0;
            endcase
        end
    end

    // Register the readback on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    // R8: read data moves only on a completing read transaction.
    a_r8_rdat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(rdat_q));
    // R3: readback holds between read strobes.
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
endmodule

// File: rtl/recfg_port_regs.sv
// Module: top of the register-mapped reconfiguration port bridge.
// Connects the host register file to the transaction engine.
// Assumes a single host master and a component that answers with port_rdy.
module recfg_port_regs #(
    parameter int          HOST_AW   = 8,
    parameter int          PA_W      = 10,
    parameter int          PD_W      = 16,
    parameter int          TIMEOUT   = 64,
    parameter logic [31:0] NEXT_PTR  = 32'h0,
    parameter logic [31:0] INFO_WORD = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               port_en,
    output logic               port_we,
    output logic [PA_W-1:0]    port_addr,
    output logic [PD_W-1:0]    port_wdata,
    input  logic [PD_W-1:0]    port_rdata,
    input  logic               port_rdy
);
    logic            busy, we_bit, cap_en, ctrl_accept, start, wbit;
    logic [PD_W-1:0] cap_data;

    recfg_reg_file #(
        .HOST_AW(HOST_AW), .PA_W(PA_W), .PD_W(PD_W),
        .NEXT_PTR(NEXT_PTR), .INFO_WORD(INFO_WORD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .we_bit(we_bit), .cap_en(cap_en), .cap_data(cap_data),
        .ctrl_accept(ctrl_accept), .start(start), .wbit(wbit),
        .addr_q(port_addr), .wdat_q(port_wdata)
    );

    recfg_xact_engine #(.PD_W(PD_W), .TIMEOUT(TIMEOUT)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .ctrl_accept(ctrl_accept), .start(start), .wbit(wbit),
        .port_rdy(port_rdy), .port_rdata(port_rdata),
        .port_en(port_en), .port_we(port_we),
        .busy(busy), .we_bit(we_bit),
        .cap_en(cap_en), .cap_data(cap_data)
    );
endmodule

// File: tb/sim_recfg_port_regs.sv
module sim_recfg_port_regs;
    localparam int PA_W = 10;
    localparam int PD_W = 16;
    localparam int TMO  = 24;
    localparam logic [31:0] NXT = 32'h0000_1000;
    localparam logic [31:0] INF = 32'h0000_ABCD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        port_en, port_we;
    logic [PA_W-1:0] port_addr;
    logic [PD_W-1:0] port_wdata;
    logic [PD_W-1:0] port_rdata = '0;
    logic        port_rdy = 1'b0;

    int errors = 0, checks = 0;
    bit done = 0;
    string cur_req = "R3";

    always #5 clk = ~clk;

    recfg_port_regs #(.HOST_AW(8), .PA_W(PA_W), .PD_W(PD_W), .TIMEOUT(TMO),
                      .NEXT_PTR(NXT), .INFO_WORD(INF)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata), .port_rdy(port_rdy));

    // Behavioural reference state
    bit      m_busy, m_wb, m_en, m_we;
    int      m_age;
    longint  m_addr, m_wd, m_rd, m_hr;

    function automatic longint view(input int off);
        if (off >= 32) return 0;
        case (off / 4)
            0: return 32'h0000C150;
            1: return 32'h00000100;
            2: return NXT;
            3: return INF;
            4: return (m_busy ? 32'h101 : 0) + (m_wb ? 2 : 0);
            5: return m_addr;
            6: return m_wd;
            default: return m_rd;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_wb = 0; m_en = 0; m_we = 0; m_age = 0;
            m_addr = 0; m_wd = 0; m_rd = 0; m_hr = 0;
        end else begin
            bit acc, launch;
            if (host_rd) m_hr = view(int'(host_addr));
            acc = host_wr && host_addr[7:2] == 6'd4 && !m_busy;
            launch = acc && host_wdata[0];
            m_en = launch;
            m_we = launch && host_wdata[1];
            if (launch) begin
                m_busy = 1; m_age = 0;
            end else if (m_busy) begin
                if (port_rdy) begin
                    if (!m_wb) m_rd = port_rdata;
                    m_busy = 0;
                end else if (m_age == TMO - 1) m_busy = 0;
                else m_age++;
            end
            if (acc) m_wb = host_wdata[1];
            if (host_wr && host_addr == 8'h14) m_addr = host_wdata % (1 << PA_W);
            if (host_wr && host_addr == 8'h18) m_wd = host_wdata % (1 << PD_W);
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) if (rst_n && !done) begin
        chk("R6", port_en, m_en);
        chk("R6", port_we, m_we);
        chk("R4", port_addr, m_addr);
        chk("R5", port_wdata, m_wd);
        chk(cur_req, host_rdata, m_hr);
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        host_addr = a; host_rd = 1;
        @(negedge clk); host_rd = 0; d = host_rdata;
    endtask

    task automatic ready(input logic [PD_W-1:0] d);
        port_rdy = 1; port_rdata = d;
        @(negedge clk); port_rdy = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R2", port_en, 0); chk("R2", host_rdata, 0);
        rst_n = 1; @(negedge clk);
        rd(8'h10, v); chk("R2", v, 0);
        rd(8'h1C, v); chk("R2", v, 0);
        // header
        cur_req = "R1";
        rd(8'h00, v); chk("R1", v, 32'h0000C150);
        rd(8'h04, v); chk("R1", v, 32'h00000100);
        rd(8'h08, v); chk("R1", v, NXT);
        rd(8'h0C, v); chk("R1", v, INF);
        wr(8'h00, 32'hFFFFFFFF); wr(8'h0C, 32'h0);
        rd(8'h00, v); chk("R1", v, 32'h0000C150);
        rd(8'h0C, v); chk("R1", v, INF);
        // masking and direct drive
        cur_req = "R3";
        wr(8'h14, 32'hFFFFFFFF);
        rd(8'h14, v); chk("R3", v, 32'h3FF); chk("R4", port_addr, 10'h3FF);
        wr(8'h18, 32'h12345678);
        rd(8'h18, v); chk("R3", v, 32'h5678); chk("R5", port_wdata, 16'h5678);
        rd(8'h20, v); chk("R3", v, 0);
        rd(8'h40, v); chk("R3", v, 0);
        // read transaction, ready a few cycles later
        cur_req = "R7";
        wr(8'h14, 32'h2A);
        wr(8'h10, 32'h1);
        chk("R6", port_en, 1); chk("R6", port_we, 0);
        @(negedge clk); chk("R6", port_en, 0);
        rd(8'h10, v); chk("R7", v, 32'h101);
        ready(16'hBEEF);
        rd(8'h10, v); chk("R7", v, 32'h0);
        rd(8'h1C, v); chk("R8", v, 32'hBEEF);
        // read transaction with ready in the strobe cycle
        wr(8'h10, 32'h1);
        chk("R6", port_en, 1);
        ready(16'h4242);
        rd(8'h10, v); chk("R7", v, 32'h0);
        rd(8'h1C, v); chk("R8", v, 32'h4242);
        // write transaction and relaunch attempt
        cur_req = "R9";
        wr(8'h10, 32'h3);
        chk("R6", port_we, 1);
        wr(8'h10, 32'h1);
        chk("R9", port_en, 0);
        rd(8'h10, v); chk("R9", v, 32'h103);
        ready(16'h1111);
        rd(8'h10, v); chk("R7", v, 32'h2);
        rd(8'h1C, v); chk("R8", v, 32'h4242);
        // ready while idle
        cur_req = "R11";
        ready(16'h7777);
        rd(8'h1C, v); chk("R11", v, 32'h4242);
        rd(8'h10, v); chk("R11", v, 32'h2);
        // timeout, polled every cycle
        cur_req = "R10";
        wr(8'h10, 32'h1);
        host_addr = 8'h10; host_rd = 1;
        repeat (TMO + 4) @(negedge clk);
        host_rd = 0;
        chk("R10", host_rdata, 32'h0);
        rd(8'h1C, v); chk("R10", v, 32'h4242);
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule